// File: doc/BRIEF.md
# 8-bit Add/Transfer Datapath with Condition Codes

This block is the small arithmetic slice of a byte-wide processor core. On each clock edge where the write enable is high, it takes two byte operands (`opa` plays the role of the A accumulator and `opb` of the B accumulator or the memory operand) and a 3-bit operation code. It then registers an 8-bit result and updates a condition-code byte that it holds itself. It can also add the B operand into a 16-bit index value and register the sum.

Each operation class carries its own flag-update mask. The two add operations rewrite the half-carry, negative, zero, overflow and carry flags. The load and accumulator-copy operations rewrite only negative and zero, and force overflow to zero. The generic transfer, the index add and the reserved code leave every flag untouched. The three control bits at the top of the flag byte (S, X, I) are held and never modified. Instruction fetch and decode stay outside: a sequencer drives `op_sel` directly.

Top module: `alu8_cc_unit`

## Requirements
- R1: Operation codes are ADD=0, ABA=1, LOAD=2, TAB=3, TBA=4, TFR=5, ABX=6, and 7 is reserved. For ADD and ABA the registered result is (opa+opb) mod 256, and flag C (bit 0) is set exactly when the 9-bit sum exceeds 255.
- R2: For ADD and ABA, flag V (bit 1) is set exactly when both operands share a sign bit and the sum's bit 7 differs from it. For example, $73+$40 gives $B3 with N=1, Z=0, V=1, C=0.
- R3: For ADD and ABA, flag H (bit 5) is set exactly when opa[3:0]+opb[3:0] exceeds 15.
- R4: For ADD, ABA, LOAD, TAB and TBA, flag Z (bit 2) is set exactly when the new result is zero, and flag N (bit 3) equals the new result's bit 7.
- R5: LOAD and TBA register opb and TAB registers opa. For all three, V is forced to 0 and H and C keep their old values.
- R6: TFR registers opa as the result and leaves the whole flag byte unchanged.
- R7: ABX registers idx_in + zero-extended opb (mod 65536) on idx_out, and leaves the result and the flags unchanged.
- R8: Bits S (7), X (6) and I (4) never change after reset.
- R9: When wr_en is low, or the op code is the reserved 7, the result, idx_out and ccr all keep their values.
- R10: While rst_n is low at a clock edge, result and idx_out clear to 0 and ccr loads CCR_RESET (default $D0).
- R11: Outputs change only at the clock edge where the operation is presented. The new values are visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Perform the selected operation at this edge |
| op_sel | input | 3 | Operation code (see R1) |
| opa | input | 8 | A operand |
| opb | input | 8 | B / memory operand |
| idx_in | input | 16 | Index value for ABX |
| result | output | 8 | Registered byte result |
| idx_out | output | 16 | Registered index sum |
| ccr | output | 8 | Condition-code byte S X H I N Z V C |

## Verification
On every cycle, embedded properties check the following: S, X and I stay fixed; a disabled or reserved cycle leaves all state alone; TFR and ABX keep the flags; loads and copies leave V clear with H and C held; and Z and N agree with the registered result after any flag-writing operation. The arithmetic values themselves (sums, carries, half-carries, overflow in every sign pairing, index wrap) can only be shown by the bench. It compares the outputs against its own model under directed corners and seeded random sequences.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag bit positions for the
// byte datapath. Assumes a 3-bit operation select.
package alu8_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ABA  = 3'd1,
        OP_LOAD = 3'd2,
        OP_TAB  = 3'd3,
        OP_TBA  = 3'd4,
        OP_TFR  = 3'd5,
        OP_ABX  = 3'd6,
        OP_RSV  = 3'd7
    } alu_op_e;

    localparam int FB_C = 0;
    localparam int FB_V = 1;
    localparam int FB_Z = 2;
    localparam int FB_N = 3;
    localparam int FB_I = 4;
    localparam int FB_H = 5;
    localparam int FB_X = 6;
    localparam int FB_S = 7;
    localparam int FLAG_W = 8;

    // Mask of the bits that are never written by any operation.
    localparam logic [FLAG_W-1:0] HOLD_MASK =
        FLAG_W'((1 << FB_S) | (1 << FB_X) | (1 << FB_I));
endpackage

// File: rtl/alu8_adder.sv
// Module: alu8_adder
// Purpose: unsigned add of two W-bit operands with carry-out, carry out of
// the low nibble and two's-complement overflow. Purely combinational.
// Assumes W >= 5 so that a nibble boundary exists.
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         half,
    output logic         ovf
);
    localparam int NIB = 4;

    logic [W:0]   full;
    logic [NIB:0] low;

    // Full-width sum and carry out of the top bit.
    always_comb begin
        full  = {1'b0, a} + {1'b0, b};
        sum   = full[W-1:0];
        carry = full[W];
    end

    // Carry from the low nibble into the next bit.
    always_comb begin
        low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
        half = low[NIB];
    end

    // Signed overflow: same operand signs, different result sign.
    always_comb begin
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_idx_add.sv
// Module: alu8_idx_add
// Purpose: adds a zero-extended AW-bit accumulator into an IW-bit index,
// wrapping modulo 2**IW. Combinational. Assumes IW > AW.
module alu8_idx_add #(
    parameter int IW = 16,
    parameter int AW = 8
) (
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] acc,
    output logic [IW-1:0] sum
);
    localparam int PAD = IW - AW;

    // Zero-extend the accumulator and add.
    always_comb begin
        sum = idx + {{PAD{1'b0}}, acc};
    end
endmodule

// File: rtl/alu8_flag_unit.sv
// Module: alu8_flag_unit
// Purpose: computes candidate flag values for the chosen operation and
// merges them into the old flag byte through a per-operation mask.
// Assumes the flag layout of alu8_pkg; held bits are never in a mask.
module alu8_flag_unit
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      res,
    input  logic              add_c,
    input  logic              add_h,
    input  logic              add_v,
    input  logic [FLAG_W-1:0] old_ccr,
    output logic [FLAG_W-1:0] new_ccr
);
    logic [FLAG_W-1:0] calc;
    logic [FLAG_W-1:0] upd;

    // Candidate flag values, valid only where the mask selects them.
    always_comb begin
        calc       = '0;
        calc[FB_N] = res[W-1];
        calc[FB_Z] = (res == '0);
        calc[FB_C] = add_c;
        calc[FB_H] = add_h;
        calc[FB_V] = (op == OP_ADD || op == OP_ABA) ? add_v : 1'b0;
    end

    // Per-operation update mask.
    always_comb begin
        upd = '0;
        unique case (op)
            OP_ADD, OP_ABA: begin
                upd[FB_H] = 1'b1;
                upd[FB_N] = 1'b1;
                upd[FB_Z] = 1'b1;
                upd[FB_V] = 1'b1;
                upd[FB_C] = 1'b1;
            end
            OP_LOAD, OP_TAB, OP_TBA: begin
                upd[FB_N] = 1'b1;
                upd[FB_Z] = 1'b1;
                upd[FB_V] = 1'b1;
            end
            default: upd = '0;
        endcase
        upd = upd & ~HOLD_MASK;
    end

    // Merge the masked candidates into the old byte.
    always_comb begin
        new_ccr = (old_ccr & ~upd) | (calc & upd);
    end
endmodule

// File: rtl/alu8_cc_unit.sv
// Module: alu8_cc_unit (top)
// Purpose: registers the byte result, the index sum and the condition-code
// byte for one add/transfer operation per enabled clock edge.
// Assumes a synchronous active-low reset and a sequencer that presents the
// operands together with op_sel and wr_en for one cycle.
module alu8_cc_unit
    import alu8_pkg::*;
#(
    parameter int               DW        = 8,
    parameter int               IW        = 16,
    parameter logic [FLAG_W-1:0] CCR_RESET = 8'hD0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [IW-1:0] idx_in,
    output logic [DW-1:0] result,
    output logic [IW-1:0] idx_out,
    output logic [FLAG_W-1:0] ccr
);
    alu_op_e           op;
    logic [DW-1:0]     add_sum;
    logic              add_c;
    logic              add_h;
    logic              add_v;
    logic [DW-1:0]     res_nxt;
    logic [IW-1:0]     idx_nxt;
    logic [FLAG_W-1:0] ccr_nxt;
    logic              res_we;
    logic              idx_we;
    logic              ccr_we;

    // Decode the raw select into the operation type.
    always_comb begin
        op = alu_op_e'(op_sel);
    end

    alu8_adder #(.W(DW)) u_add (
        .a     (opa),
        .b     (opb),
        .sum   (add_sum),
        .carry (add_c),
        .half  (add_h),
        .ovf   (add_v)
    );

    alu8_idx_add #(.IW(IW), .AW(DW)) u_idx (
        .idx (idx_in),
        .acc (opb),
        .sum (idx_nxt)
    );

    // Result selection per operation.
    always_comb begin
        unique case (op)
            OP_ADD, OP_ABA:   res_nxt = add_sum;
            OP_LOAD, OP_TBA:  res_nxt = opb;
            OP_TAB, OP_TFR:   res_nxt = opa;
            default:          res_nxt = result;
        endcase
    end

    alu8_flag_unit #(.W(DW)) u_flag (
        .op      (op),
        .res     (res_nxt),
        .add_c   (add_c),
        .add_h   (add_h),
        .add_v   (add_v),
        .old_ccr (ccr),
        .new_ccr (ccr_nxt)
    );

    // Write enables for each register.
    always_comb begin
        res_we = wr_en && (op != OP_ABX) && (op != OP_RSV);
        idx_we = wr_en && (op == OP_ABX);
        ccr_we = wr_en && (op != OP_RSV);
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            idx_out <= '0;
            ccr     <= CCR_RESET;
        end else begin
            if (res_we) result  <= res_nxt;
            if (idx_we) idx_out <= idx_nxt;
            if (ccr_we) ccr     <= ccr_nxt;
        end
    end

    // Control bits S, X, I never move once out of reset (R8).
    p_ctl_bits_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ccr[FB_S] == $past(ccr[FB_S]) && ccr[FB_X] == $past(ccr[FB_X])
                          && ccr[FB_I] == $past(ccr[FB_I])));

    // Disabled or reserved cycle changes nothing (R9).
    p_idle_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || op_sel == 3'd7) |=> ($stable(result) && $stable(idx_out) && $stable(ccr)));

    // Transfer and index add keep the flag byte (R6, R7).
    p_keep_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op_sel == 3'd5 || op_sel == 3'd6)) |=> $stable(ccr));

    // Index add leaves the result alone (R7).
    p_abx_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_sel == 3'd6) |=> $stable(result));

    // Loads and copies clear V and keep H and C (R5).
    p_load_v_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_sel >= 3'd2 && op_sel <= 3'd4)
        |=> (!ccr[FB_V] && $stable(ccr[FB_H]) && $stable(ccr[FB_C])));

    // Z and N agree with the new result after flag-writing ops (R4).
    p_zn_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_sel <= 3'd4)
        |=> (ccr[FB_Z] == (result == '0) && ccr[FB_N] == result[DW-1]));
endmodule

// File: tb/alu8_cc_unit_tb_top.sv
module alu8_cc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  op_sel;
    logic [7:0]  opa, opb;
    logic [15:0] idx_in;
    logic [7:0]  result;
    logic [15:0] idx_out;
    logic [7:0]  ccr;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  m_res;
    logic [15:0] m_idx;
    logic [7:0]  m_ccr;

    always #2.5 clk = ~clk;

    alu8_cc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_sel(op_sel),
        .opa(opa), .opb(opb), .idx_in(idx_in),
        .result(result), .idx_out(idx_out), .ccr(ccr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic en);
        if (!en || o == 3'd7) return "R9";
        case (o)
            3'd0, 3'd1: return "R1/R2/R3 add";
            3'd2, 3'd3, 3'd4: return "R5 load/copy";
            3'd5: return "R6 transfer";
            default: return "R7 index add";
        endcase
    endfunction

    // Reference model, built from the requirement text.
    task automatic model(input logic en, input logic [2:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic [15:0] ix);
        int s;
        logic [7:0] r;
        if (!en || o == 3'd7) return;
        if (o <= 3'd1) begin
            s = int'(a) + int'(b);
            r = s[7:0];
            m_ccr[0] = (s > 255);
            m_ccr[1] = (a[7] == b[7]) && (r[7] != a[7]);
            m_ccr[5] = (int'(a[3:0]) + int'(b[3:0])) > 15;
            m_ccr[2] = (r == 8'h00);
            m_ccr[3] = r[7];
            m_res = r;
        end else if (o <= 3'd4) begin
            r = (o == 3'd3) ? a : b;
            m_ccr[1] = 1'b0;
            m_ccr[2] = (r == 8'h00);
            m_ccr[3] = r[7];
            m_res = r;
        end else if (o == 3'd5) begin
            m_res = a;
        end else begin
            m_idx = ix + {8'h00, b};
        end
    endtask

    task automatic step(input logic en, input logic [2:0] o, input logic [7:0] a,
                        input logic [7:0] b, input logic [15:0] ix);
        string t;
        t = tag_of(o, en);
        wr_en = en; op_sel = o; opa = a; opb = b; idx_in = ix;
        model(en, o, a, b, ix);
        @(posedge clk);
        @(negedge clk);
        check({t, " R11 result"}, 32'(result), 32'(m_res));
        check({t, " R7 idx"}, 32'(idx_out), 32'(m_idx));
        check({t, " R8 ccr"}, 32'(ccr), 32'(m_ccr));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst_n = 1'b0; wr_en = 1'b0; op_sel = '0; opa = '0; opb = '0; idx_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_res = 8'h00; m_idx = 16'h0000; m_ccr = 8'hD0;
        check("R10 reset result", 32'(result), 32'h00);
        check("R10 reset idx", 32'(idx_out), 32'h0000);
        check("R10 reset ccr", 32'(ccr), 32'hD0);
        rst_n = 1'b1;

        // R2 worked example: $73 + $40 -> $B3, N=1 V=1 C=0 Z=0
        step(1'b1, 3'd0, 8'h73, 8'h40, 16'h0);
        check("R2 example N", 32'(ccr[3]), 32'd1);
        check("R2 example V", 32'(ccr[1]), 32'd1);
        // R1 carry with zero result; all sign pairings for R2
        step(1'b1, 3'd0, 8'hFF, 8'h01, 16'h0);
        step(1'b1, 3'd1, 8'h7F, 8'h01, 16'h0);
        step(1'b1, 3'd0, 8'h80, 8'h80, 16'h0);
        step(1'b1, 3'd1, 8'h90, 8'h10, 16'h0);
        step(1'b1, 3'd0, 8'h20, 8'hF0, 16'h0);
        step(1'b1, 3'd0, 8'h10, 8'h20, 16'h0);
        // R3 half carry boundaries
        step(1'b1, 3'd0, 8'h0F, 8'h01, 16'h0);
        step(1'b1, 3'd0, 8'h0E, 8'h01, 16'h0);
        // R5 loads and copies, R4 zero and negative
        step(1'b1, 3'd2, 8'h55, 8'h00, 16'h0);
        step(1'b1, 3'd3, 8'h80, 8'h01, 16'h0);
        step(1'b1, 3'd4, 8'h00, 8'h7E, 16'h0);
        // R6 generic transfer after flags set
        step(1'b1, 3'd0, 8'h7F, 8'h7F, 16'h0);
        step(1'b1, 3'd5, 8'h00, 8'h33, 16'h0);
        // R7 index add with wrap
        step(1'b1, 3'd6, 8'h11, 8'hFF, 16'hFFFF);
        step(1'b1, 3'd6, 8'h11, 8'h80, 16'h1234);
        // R9 disabled and reserved
        step(1'b0, 3'd0, 8'hFF, 8'hFF, 16'h0);
        step(1'b1, 3'd7, 8'hFF, 8'hFF, 16'hAAAA);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom();
            step(rv[3:0] != 4'd0, rv[6:4], $urandom(), $urandom(), 16'($urandom()));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule